// File: doc/BRIEF.md
# Byte-Command GPIO Bank Engine

This block drives sixteen bidirectional pins, split into two banks of eight, under the control of a byte stream. Commands arrive one byte per handshake on a valid/ready input. A set command carries an opcode byte, an output-value byte and a direction byte, and updates one bank. A get command is a single opcode byte. It answers on a valid/ready output stream with two status bytes followed by the bank's synchronised pin levels.

The engine is gated by a mode register. Commands only act after a reset value (0) and then a command-mode value (2) have been written to it, in that order. A build-time capability mask marks which pins may ever be driven. Direction bits for all other pins are forced low, whatever a host writes. Opcodes that match neither command are swallowed and recorded in a sticky flag that the host sees in the second status byte.

Top module: `gpio_cmd_engine`

## Requirements
- R1: After reset, pad_out and pad_oe are all zero, rsp_valid is 0 and cmd_ready is 1.
- R2: Command bytes change nothing until a mode write of 0 is followed by a mode write of 2. A write of 2 without a preceding 0 leaves the engine inert. Any value other than 0 or 2 disables it. Bytes sent while the engine is inert are accepted (cmd_ready high) and discarded.
- R3: A set frame is opcode 0x80 (low bank, pins 0-7) or 0x82 (high bank, pins 8-15), with the bank taken from opcode bit 1. It is followed by a value byte and a direction byte. Bit i of the value byte drives pad_out[bank*8+i]. Bit i of the direction byte set to 1 makes that pin an output (pad_oe high), and 0 makes it an input.
- R4: A set frame changes pad_out and pad_oe only on the handshake of its third byte, both in that same clock edge. After only the opcode and the value byte, the pins are unchanged.
- R5: pad_oe stays 0 for every pin whose bit in OUT_CAP is 0, whatever direction byte is written.
- R6: A get opcode, 0x81 (low bank) or 0x83 (high bank), yields exactly three reply bytes: STAT_HI, then STAT_LO with bit 1 replaced by the bad-command flag, then the bank's pin levels with bit i = pin bank*8+i.
- R7: The pin levels returned by get pass through a two-stage synchroniser. A get opcode accepted on the second clock edge after pad_in changes still returns the old level.
- R8: A byte in opcode position other than 0x80-0x83 is consumed and discarded, and the next byte is treated as an opcode. The byte sets the sticky bad-command flag. The flag is cleared only by reset or by a mode write of 0.
- R9: While a reply byte is offered and rsp_ready is low, rsp_valid and rsp_data hold, and cmd_ready stays low until the last reply byte has been taken.
- R10: A set frame for one bank leaves the other bank's pad_out and pad_oe bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_val | input | 8 | Mode value: 0 reset, 2 command mode |
| cmd_data | input | 8 | Command byte |
| cmd_valid | input | 1 | Command byte valid |
| cmd_ready | output | 1 | Engine can take a command byte |
| rsp_data | output | 8 | Reply byte |
| rsp_valid | output | 1 | Reply byte valid |
| rsp_ready | input | 1 | Consumer takes the reply byte |
| pad_in | input | 16 | Raw pin levels |
| pad_out | output | 16 | Pin output values |
| pad_oe | output | 16 | Pin output enables (1 = drive) |

## Verification
The bench probes the mode sequence in both wrong orders. A design that enables on a lone command-mode write, or stays enabled after an odd mode value, changes the pins when it should not. It stops a set frame after two bytes to catch designs that update the value early, and it writes all-ones directions onto pins outside the capability mask. It also issues a get right after a pin change: a design with one synchroniser stage, or none, returns the new level too soon. Finally, it follows an unknown opcode with a valid get to catch a parser that loses its frame position or drops the sticky flag, and it stalls the reply stream to catch data that moves without a handshake.

// File: rtl/gpio_cmd_pkg.sv
// Package: shared constants, types and the opcode decoder for the GPIO
// command engine. Assumes 8-bit command bytes and exactly two banks (the
// bank index is one opcode bit).
package gpio_cmd_pkg;

    localparam int BYTE_W   = 8;
    localparam int N_BANKS  = 2;
    localparam int N_PINS   = BYTE_W * N_BANKS;
    localparam int BANK_BIT = 1;

    localparam logic [BYTE_W-1:0] OP_SET      = 8'h80;
    localparam logic [BYTE_W-1:0] OP_GET      = 8'h81;
    localparam logic [BYTE_W-1:0] MODE_RESET  = 8'h00;
    localparam logic [BYTE_W-1:0] MODE_CMD    = 8'h02;

    typedef enum logic [1:0] {
        PS_OPCODE = 2'd0,
        PS_VALUE  = 2'd1,
        PS_DIR    = 2'd2
    } parse_st_t;

    typedef enum logic [1:0] {
        MD_OFF    = 2'd0,
        MD_PRIMED = 2'd1,
        MD_ON     = 2'd2
    } mode_st_t;

    typedef enum logic [1:0] {
        OPK_SET = 2'd0,
        OPK_GET = 2'd1,
        OPK_BAD = 2'd2
    } op_kind_t;

    typedef struct packed {
        logic [BYTE_W-1:0] val;
        logic [BYTE_W-1:0] dir;
        logic              bank;
    } set_req_t;

    // Classify an opcode byte once its bank bit has been cleared.
    function automatic op_kind_t decode_op(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] base;
        base = b & ~(BYTE_W'(1) << BANK_BIT);
        if (base == OP_SET)      return OPK_SET;
        else if (base == OP_GET) return OPK_GET;
        else                     return OPK_BAD;
    endfunction

endpackage

// File: rtl/gpio_mode_ctl.sv
// Mode register sequencer. Commands become active only after a reset-value
// write followed by a command-mode write. Any other value turns the engine
// off. Assumes mode_wr is a single-cycle strobe in the clk domain.
module gpio_mode_ctl
    import gpio_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [BYTE_W-1:0] mode_val,
    output logic              active,
    output logic              flush,
    output logic              clr_flag
);

    mode_st_t st_q;

    // Track the reset-then-command-mode sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= MD_OFF;
        end else if (mode_wr) begin
            if (mode_val == MODE_RESET)
                st_q <= MD_PRIMED;
            else if (mode_val == MODE_CMD)
                st_q <= (st_q == MD_OFF) ? MD_OFF : MD_ON;
            else
                st_q <= MD_OFF;
        end
    end

    // Decode strobes for the parser.
    always_comb begin
        active   = (st_q == MD_ON);
        flush    = mode_wr;
        clr_flag = mode_wr && (mode_val == MODE_RESET);
    end

endmodule

// File: rtl/gpio_cmd_parser.sv
// Command byte parser. Walks opcode, value and direction bytes. It issues a
// set strobe on the third byte of a set frame and a get strobe on a get
// opcode, and keeps a sticky flag for unknown opcodes. Assumes byte_fire is
// already qualified by the handshake and the mode state.
module gpio_cmd_parser
    import gpio_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_fire,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              flush,
    input  logic              clr_flag,
    output logic              set_stb,
    output set_req_t          set_req,
    output logic              get_stb,
    output logic              get_bank,
    output logic              bad_flag
);

    parse_st_t         st_q;
    logic              bank_q;
    logic [BYTE_W-1:0] val_q;
    op_kind_t          kind;

    // Classify the current byte as an opcode.
    always_comb kind = decode_op(byte_data);

    // Frame position, captured bank and value byte, sticky bad flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= PS_OPCODE;
            bank_q   <= 1'b0;
            val_q    <= '0;
            bad_flag <= 1'b0;
        end else begin
            if (clr_flag)
                bad_flag <= 1'b0;
            if (flush) begin
                st_q <= PS_OPCODE;
            end else if (byte_fire) begin
                case (st_q)
                    PS_OPCODE: begin
                        if (kind == OPK_SET) begin
                            bank_q <= byte_data[BANK_BIT];
                            st_q   <= PS_VALUE;
                        end else if (kind == OPK_BAD) begin
                            bad_flag <= 1'b1;
                        end
                    end
                    PS_VALUE: begin
                        val_q <= byte_data;
                        st_q  <= PS_DIR;
                    end
                    default: st_q <= PS_OPCODE;
                endcase
            end
        end
    end

    // Strobes towards the bank registers and the reply serialiser.
    always_comb begin
        set_stb      = byte_fire && !flush && (st_q == PS_DIR);
        set_req.val  = val_q;
        set_req.dir  = byte_data;
        set_req.bank = bank_q;
        get_stb      = byte_fire && !flush && (st_q == PS_OPCODE) && (kind == OPK_GET);
        get_bank     = byte_data[BANK_BIT];
    end

endmodule

// File: rtl/gpio_bank_regs.sv
// Per-bank output value and direction registers. A set request updates both
// registers of the addressed bank in one edge. Direction bits of pins that
// lack output capability are forced to zero.
module gpio_bank_regs
    import gpio_cmd_pkg::*;
#(
    parameter logic [N_PINS-1:0] OUT_CAP = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_stb,
    input  set_req_t          set_req,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe
);

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        localparam logic [BYTE_W-1:0] CAP = OUT_CAP[b*BYTE_W +: BYTE_W];
        logic [BYTE_W-1:0] out_q;
        logic [BYTE_W-1:0] dir_q;

        // Load value and masked direction when this bank is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_q <= '0;
                dir_q <= '0;
            end else if (set_stb && (set_req.bank == 1'(b))) begin
                out_q <= set_req.val;
                dir_q <= set_req.dir & CAP;
            end
        end

        // Map bank registers onto the pin vectors.
        always_comb begin
            pad_out[b*BYTE_W +: BYTE_W] = out_q;
            pad_oe[b*BYTE_W +: BYTE_W]  = dir_q;
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Multi-stage flop synchroniser for the raw pin levels. Assumes the pins
// are quasi-static relative to clk; there is no glitch filtering.
module gpio_in_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // One flop stage of the chain.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stg[s] <= '0;
            else if (s == 0)
                stg[s] <= d;
            else
                stg[s] <= stg[(s == 0) ? 0 : s-1];
        end
    end

    // The last stage feeds the reply path.
    always_comb q = stg[STAGES-1];

endmodule

// File: rtl/gpio_rsp_tx.sv
// Reply serialiser. On a get strobe it loads two status bytes and the
// bank's levels, then offers them one per handshake. Assumes no get strobe
// arrives while busy (the top holds cmd_ready low then).
module gpio_rsp_tx
    import gpio_cmd_pkg::*;
#(
    parameter logic [BYTE_W-1:0] STAT_HI = 8'h32,
    parameter logic [BYTE_W-1:0] STAT_LO = 8'h60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              get_stb,
    input  logic              get_bank,
    input  logic [N_PINS-1:0] levels,
    input  logic              bad_flag,
    output logic [BYTE_W-1:0] rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              busy
);

    localparam int REPLY_LEN = 3;
    localparam int CNT_W     = $clog2(REPLY_LEN + 1);

    logic [CNT_W-1:0]  left_q;
    logic [BYTE_W-1:0] q0, q1, q2;
    logic [BYTE_W-1:0] status_lo;
    logic [BYTE_W-1:0] bank_lvl;

    // Second status byte carries the sticky flag; pick the addressed bank.
    always_comb begin
        status_lo = STAT_LO;
        status_lo[1] = bad_flag;
        bank_lvl = get_bank ? levels[BYTE_W +: BYTE_W] : levels[0 +: BYTE_W];
    end

    // Load on get, shift on each accepted reply byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            q0 <= '0;
            q1 <= '0;
            q2 <= '0;
        end else if (get_stb) begin
            q0     <= STAT_HI;
            q1     <= status_lo;
            q2     <= bank_lvl;
            left_q <= CNT_W'(REPLY_LEN);
        end else if ((left_q != '0) && rsp_ready) begin
            q0     <= q1;
            q1     <= q2;
            left_q <= left_q - CNT_W'(1);
        end
    end

    // Present the head byte.
    always_comb begin
        rsp_valid = (left_q != '0);
        rsp_data  = q0;
        busy      = rsp_valid;
    end

endmodule

// File: rtl/gpio_cmd_engine.sv
// Top of the byte-command GPIO bank engine. Joins the mode sequencer,
// parser, bank registers, input synchroniser and reply serialiser. Command
// bytes are refused only while a reply is outstanding.
module gpio_cmd_engine
    import gpio_cmd_pkg::*;
#(
    parameter logic [15:0] OUT_CAP     = 16'hFFFF,
    parameter logic [7:0]  STAT_HI     = 8'h32,
    parameter logic [7:0]  STAT_LO     = 8'h60,
    parameter int          SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_wr,
    input  logic [7:0]  mode_val,
    input  logic [7:0]  cmd_data,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    output logic [7:0]  rsp_data,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    input  logic [15:0] pad_in,
    output logic [15:0] pad_out,
    output logic [15:0] pad_oe
);

    logic        mode_active;
    logic        flush;
    logic        clr_flag;
    logic        byte_fire;
    logic        set_stb;
    set_req_t    set_req;
    logic        get_stb;
    logic        get_bank;
    logic        bad_flag;
    logic        busy;
    logic [15:0] levels;

    // Accept gating: refuse only while replying; act only when active.
    always_comb begin
        cmd_ready = !busy;
        byte_fire = cmd_valid && cmd_ready && mode_active && !mode_wr;
    end

    gpio_mode_ctl u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_wr  (mode_wr),
        .mode_val (mode_val),
        .active   (mode_active),
        .flush    (flush),
        .clr_flag (clr_flag)
    );

    gpio_cmd_parser u_parse (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_fire (byte_fire),
        .byte_data (cmd_data),
        .flush     (flush),
        .clr_flag  (clr_flag),
        .set_stb   (set_stb),
        .set_req   (set_req),
        .get_stb   (get_stb),
        .get_bank  (get_bank),
        .bad_flag  (bad_flag)
    );

    gpio_bank_regs #(.OUT_CAP(OUT_CAP)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (set_stb),
        .set_req (set_req),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    gpio_in_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (levels)
    );

    gpio_rsp_tx #(.STAT_HI(STAT_HI), .STAT_LO(STAT_LO)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .get_stb   (get_stb),
        .get_bank  (get_bank),
        .levels    (levels),
        .bad_flag  (bad_flag),
        .rsp_data  (rsp_data),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .busy      (busy)
    );

endmodule

// File: rtl/gpio_cmd_engine_chk.sv
// Protocol and pin checker for gpio_cmd_engine, attached by bind.
module gpio_cmd_engine_chk #(
    parameter logic [15:0] OUT_CAP = 16'hFFFF
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [7:0]  rsp_data,
    input logic [15:0] pad_out,
    input logic [15:0] pad_oe,
    input logic        mode_active
);

    assert_oe_capable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~OUT_CAP) == 16'h0);

    assert_reply_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready);

    assert_pins_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_ready) |=> ($stable(pad_oe) && $stable(pad_out)));

    assert_inert_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_active |=> ($stable(pad_oe) && $stable(pad_out)));

endmodule

bind gpio_cmd_engine gpio_cmd_engine_chk #(.OUT_CAP(OUT_CAP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_data    (rsp_data),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .mode_active (mode_active)
);

// File: tb/sim_gpio_cmd_engine.sv
`timescale 1ns/1ps
module sim_gpio_cmd_engine;

    localparam logic [15:0] CAP = 16'hBFF7;
    localparam logic [7:0]  SHI = 8'h32;
    localparam logic [7:0]  SLO = 8'h60;

    // {opcode, value, direction, expected pad_out, expected pad_oe}
    localparam logic [55:0] VEC [0:5] = '{
        56'h80_A5_FF_00A5_00F7,
        56'h82_3C_0F_3CA5_0FF7,
        56'h80_5A_00_3C5A_0F00,
        56'h82_FF_FF_FF5A_BF00,
        56'h80_01_08_FF01_BF00,
        56'h82_00_40_0001_0000
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0;
    logic [7:0]  mode_val = 8'h00;
    logic [7:0]  cmd_data = 8'h00;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [7:0]  rsp_data;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [15:0] pad_in = 16'h0000;
    logic [15:0] pad_out;
    logic [15:0] pad_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_cmd_engine #(.OUT_CAP(CAP), .STAT_HI(SHI), .STAT_LO(SLO)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_val(mode_val),
        .cmd_data(cmd_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .rsp_data(rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        cmd_data  = b;
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic write_mode(input logic [7:0] v);
        @(negedge clk);
        mode_wr  = 1'b1;
        mode_val = v;
        @(negedge clk);
        mode_wr  = 1'b0;
    endtask

    task automatic send_set(input logic [7:0] op, input logic [7:0] v, input logic [7:0] d);
        send_byte(op);
        send_byte(v);
        send_byte(d);
    endtask

    task automatic collect(output logic [7:0] b0, output logic [7:0] b1, output logic [7:0] b2);
        logic [7:0] r [3];
        rsp_ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            while (!rsp_valid) @(negedge clk);
            r[i] = rsp_data;
            @(negedge clk);
        end
        b0 = r[0]; b1 = r[1]; b2 = r[2];
    endtask

    task automatic do_get(input logic [7:0] op, output logic [7:0] b0, output logic [7:0] b1, output logic [7:0] b2);
        send_byte(op);
        collect(b0, b1, b2);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] s0, s1, dv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pad_out", pad_out, 16'h0);
        chk("R1 pad_oe", pad_oe, 16'h0);
        chk("R1 rsp_valid", {15'h0, rsp_valid}, 16'h0);
        chk("R1 cmd_ready", {15'h0, cmd_ready}, 16'h1);

        // R2 inert before any mode write, and after command-mode alone
        send_set(8'h80, 8'hFF, 8'hFF);
        chk("R2 no mode oe", pad_oe, 16'h0);
        chk("R2 no mode out", pad_out, 16'h0);
        write_mode(8'h02);
        send_set(8'h80, 8'hFF, 8'hFF);
        chk("R2 cmd-only oe", pad_oe, 16'h0);
        write_mode(8'h00);
        write_mode(8'h02);

        // R3 R5 R10 table of set frames
        foreach (VEC[i]) begin
            send_set(VEC[i][55:48], VEC[i][47:40], VEC[i][39:32]);
            chk($sformatf("R3 R10 vec%0d pad_out", i), pad_out, VEC[i][31:16]);
            chk($sformatf("R5 R3 vec%0d pad_oe", i), pad_oe, VEC[i][15:0]);
        end

        // R4 partial frame changes nothing; third byte applies both
        send_byte(8'h82);
        send_byte(8'h12);
        chk("R4 partial out", pad_out, 16'h0001);
        chk("R4 partial oe", pad_oe, 16'h0000);
        send_byte(8'h0F);
        chk("R4 full out", pad_out, 16'h1201);
        chk("R4 full oe", pad_oe, 16'h0F00);

        // R7 get right after a pin change returns the old level
        pad_in = 16'hC35A;
        do_get(8'h81, s0, s1, dv);
        chk("R7 early level", {8'h0, dv}, 16'h0000);

        // R6 get low and high banks
        do_get(8'h81, s0, s1, dv);
        chk("R6 status hi", {8'h0, s0}, {8'h0, SHI});
        chk("R6 status lo", {8'h0, s1}, {8'h0, SLO});
        chk("R6 low bank", {8'h0, dv}, 16'h005A);
        do_get(8'h83, s0, s1, dv);
        chk("R6 high bank", {8'h0, dv}, 16'h00C3);

        // R8 unknown opcode dropped, flag set, parser realigned
        send_byte(8'h47);
        do_get(8'h83, s0, s1, dv);
        chk("R8 flag set", {8'h0, s1}, 16'h0062);
        chk("R8 realigned", {8'h0, dv}, 16'h00C3);
        send_byte(8'h84);
        chk("R8 out kept", pad_out, 16'h1201);
        write_mode(8'h00);
        write_mode(8'h02);
        do_get(8'h81, s0, s1, dv);
        chk("R8 flag cleared", {8'h0, s1}, 16'h0060);

        // R9 reply back-pressure
        rsp_ready = 1'b0;
        send_byte(8'h83);
        repeat (3) @(negedge clk);
        chk("R9 valid held", {15'h0, rsp_valid}, 16'h1);
        chk("R9 data held", {8'h0, rsp_data}, {8'h0, SHI});
        chk("R9 ready low", {15'h0, cmd_ready}, 16'h0);
        collect(s0, s1, dv);
        chk("R9 after stall", {8'h0, dv}, 16'h00C3);
        chk("R9 ready back", {15'h0, cmd_ready}, 16'h1);

        // R2 an odd mode value disables
        write_mode(8'h05);
        send_set(8'h80, 8'h00, 8'h00);
        chk("R2 off out", pad_out, 16'h1201);
        chk("R2 off oe", pad_oe, 16'h0F00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule